// File: doc/BRIEF.md
# Sequential FIFO-Port Stream Copier

The block moves a programmed number of data words from an upstream FIFO to a downstream FIFO. It never generates an address. It pops its input side through a not-empty flag and a read strobe. It pushes its output side through a not-full flag and a write strobe. Each port carries data in one direction only.

A one-cycle start pulse, given while the block is idle, latches the word count and a transform mode. The block then copies the words in order and passes each one through the selected transform. It stalls whenever the source is empty or the sink is full. A single holding register sits between the two sides, so a word that has already been popped is never lost or repeated while the sink is full.

When the final word has been pushed, a done pulse marks completion. An optional last-write flag, selected by parameter, goes high at the same time and stays high until the next accepted start.

Top module: `fifo_stream_copier`

## Requirements
- R1: While idle, the block asserts neither `in_read_o` nor `out_write_o`, even when the source holds data and the sink has room. A transfer begins only after `start_i` is sampled high while `busy_o` is low.
- R2: `in_read_o` is high only in cycles where `in_empty_n_i` is high. While the source is empty, no word is consumed and the copy waits.
- R3: `out_write_o` is high only in cycles where `out_full_n_i` is high. While the sink is full, `out_data_o` keeps its value until the word is written.
- R4: A run writes exactly the programmed count of words, in source order, with none lost or duplicated, under any pattern of empty and full stalls.
- R5: With the source never empty and the sink never full, a run of N words raises `done_o` N+1 cycles after the clock edge that samples `start_i`, which is one word per cycle.
- R6: `mode_i` selects the transform and is latched at start. 0 passes the word through. 1 inverts every bit. 2 adds one modulo 2^DATA_W. 3 swaps the upper and lower halves of the word.
- R7: `done_o` is a single-cycle pulse in the cycle after the final write, and `busy_o` is low in that cycle.
- R8: With `LAST_WR_EN`=1, `last_wr_o` goes high together with `done_o` after a final write. It stays high while idle and clears in the cycle after the next accepted start. It is low throughout a run.
- R9: A start with a count of 0 produces a `done_o` pulse in the cycle after start and moves no words.
- R10: A `start_i` pulse given while `busy_o` is high is ignored. The current run completes with its original count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| count_i | input | CNT_W | Number of words to copy, latched at start |
| mode_i | input | 2 | Transform select, latched at start |
| in_data_i | input | DATA_W | Source FIFO head word |
| in_empty_n_i | input | 1 | Source not empty |
| in_read_o | output | 1 | Source pop strobe |
| out_data_o | output | DATA_W | Word offered to the sink FIFO |
| out_full_n_i | input | 1 | Sink not full |
| out_write_o | output | 1 | Sink push strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| last_wr_o | output | 1 | Final write has completed (held until next start) |

## Verification
The hardest case to reach from the ports is a full sink that coincides with a non-empty source while the holding register is occupied. In that state a read would overwrite an unwritten word. The bench drives the two flags with different periodic gap patterns, including a sink that is full most of the time, so this collision occurs many times within one run. It then compares the captured output stream word for word against the transformed source. A second start is also issued in the middle of a stalled run to show that the count latched at the first start is kept.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    XF_PASS = 2'd0,
    XF_INV  = 2'd1,
    XF_INC  = 2'd2,
    XF_SWAP = 2'd3
  } xform_e;
endpackage

// File: rtl/fsc_xform.sv
module fsc_xform
  import fsc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  xform_e              mode_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   data_o
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    unique case (mode_i)
      XF_INV:  data_o = ~data_i;
      XF_INC:  data_o = data_i + DATA_W'(1);
      XF_SWAP: data_o = {data_i[HALF_W-1:0], data_i[DATA_W-1:HALF_W]};
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/fsc_hold.sv
module fsc_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              drain_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      if (load_i) begin
        vld_o  <= 1'b1;
        data_o <= data_i;
      end else if (drain_i) begin
        vld_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl #(
  parameter int CNT_W      = 8,
  parameter bit LAST_WR_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rd_fire_i,
  input  logic             wr_fire_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             rd_more_o,
  output logic             done_o,
  output logic             last_wr_o
);
  logic [CNT_W-1:0] rd_left_q, wr_left_q;
  logic             last_q;

  assign accept_o  = start_i && !busy_o;
  assign rd_more_o = (rd_left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_left_q <= '0;
      wr_left_q <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      last_q    <= 1'b0;
    end else if (accept_o) begin
      rd_left_q <= count_i;
      wr_left_q <= count_i;
      busy_o    <= (count_i != '0);
      done_o    <= (count_i == '0);
      last_q    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rd_fire_i) rd_left_q <= rd_left_q - CNT_W'(1);
      if (wr_fire_i) begin
        wr_left_q <= wr_left_q - CNT_W'(1);
        if (wr_left_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          last_q <= 1'b1;
        end
      end
    end
  end

  generate
    if (LAST_WR_EN) begin : g_last
      assign last_wr_o = last_q;
    end else begin : g_no_last
      assign last_wr_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fifo_stream_copier.sv
module fifo_stream_copier
  import fsc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter bit LAST_WR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_empty_n_i,
  output logic              in_read_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_full_n_i,
  output logic              out_write_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              last_wr_o
);
  xform_e            mode_q;
  logic              accept, rd_more, hold_vld;
  logic [DATA_W-1:0] xf_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= XF_PASS;
    else if (accept) mode_q <= xform_e'(mode_i);
  end

  // pop only if the holding slot is free or drains this cycle
  assign out_write_o = hold_vld && out_full_n_i;
  assign in_read_o   = busy_o && rd_more && in_empty_n_i && (!hold_vld || out_full_n_i);

  fsc_ctrl #(.CNT_W(CNT_W), .LAST_WR_EN(LAST_WR_EN)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .count_i   (count_i),
    .rd_fire_i (in_read_o),
    .wr_fire_i (out_write_o),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .rd_more_o (rd_more),
    .done_o    (done_o),
    .last_wr_o (last_wr_o)
  );

  fsc_xform #(.DATA_W(DATA_W)) u_xform (
    .mode_i (mode_q),
    .data_i (in_data_i),
    .data_o (xf_data)
  );

  fsc_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (in_read_o),
    .data_i  (xf_data),
    .drain_i (out_write_o),
    .vld_o   (hold_vld),
    .data_o  (out_data_o)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int DATA_W     = 16,
  parameter bit LAST_WR_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_empty_n_i,
  input logic              in_read_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_full_n_i,
  input logic              out_write_o,
  input logic              hold_vld_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              last_wr_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!in_read_o && !out_write_o));

  // R2
  read_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_read_o |-> in_empty_n_i);

  // R3
  write_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_write_o |-> out_full_n_i);

  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld_i && !out_full_n_i) |=> (hold_vld_i && $stable(out_data_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  generate
    if (LAST_WR_EN) begin : g_last_chk
      // R8
      last_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(out_write_o)) |-> last_wr_o);
      // R8
      last_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !last_wr_o);
    end
  endgenerate
endmodule

bind fifo_stream_copier fsc_checker #(.DATA_W(DATA_W), .LAST_WR_EN(LAST_WR_EN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_empty_n_i (in_empty_n_i),
  .in_read_o    (in_read_o),
  .out_data_o   (out_data_o),
  .out_full_n_i (out_full_n_i),
  .out_write_o  (out_write_o),
  .hold_vld_i   (hold_vld),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .last_wr_o    (last_wr_o)
);

// File: tb/fifo_stream_copier_tb.sv
module fifo_stream_copier_tb;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic [1:0]    mode_i = '0;
  logic [DW-1:0] in_data_i;
  logic          in_empty_n_i = 1'b0;
  logic          in_read_o;
  logic [DW-1:0] out_data_o;
  logic          out_full_n_i = 1'b0;
  logic          out_write_o;
  logic          busy_o, done_o, last_wr_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] src [0:255];
  logic [DW-1:0] dst [0:255];
  int rd_ptr = 0, src_n = 0, wr_n = 0;
  int in_mod = 0, out_mod = 0, tcyc = 0;
  int rd_bad = 0, wr_bad = 0;
  logic rd_pend = 1'b0;

  always #10 clk = ~clk;

  fifo_stream_copier #(.DATA_W(DW), .CNT_W(CW), .LAST_WR_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .mode_i(mode_i), .in_data_i(in_data_i), .in_empty_n_i(in_empty_n_i),
    .in_read_o(in_read_o), .out_data_o(out_data_o), .out_full_n_i(out_full_n_i),
    .out_write_o(out_write_o), .busy_o(busy_o), .done_o(done_o), .last_wr_o(last_wr_o)
  );

  assign in_data_i = src[rd_ptr[7:0]];

  // FIFO models: update at negedge, sample strobes shortly after
  always @(negedge clk) begin
    if (rd_pend) rd_ptr = rd_ptr + 1;
    tcyc = tcyc + 1;
    in_empty_n_i = (rd_ptr < src_n) && !(in_mod > 0 && (tcyc % in_mod) == 0);
    out_full_n_i = !(out_mod > 0 && (tcyc % out_mod) != 0);
    #1;
    rd_pend = in_read_o;
    if (in_read_o && !in_empty_n_i) rd_bad = rd_bad + 1;
    if (out_write_o && !out_full_n_i) wr_bad = wr_bad + 1;
    if (out_write_o) begin
      dst[wr_n[7:0]] = out_data_o;
      wr_n = wr_n + 1;
    end
  end

  function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] d, input logic [1:0] m);
    case (m)
      2'd1:    return ~d;
      2'd2:    return d + 16'd1;
      2'd3:    return {d[7:0], d[15:8]};
      default: return d;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_src(input int n, input int seed);
    for (int i = 0; i < 256; i++) src[i] = DW'(i * 16'h0131 + seed);
    rd_ptr = 0; src_n = n; wr_n = 0; rd_bad = 0; wr_bad = 0;
  endtask

  task automatic pulse_start(input int n, input logic [1:0] m);
    @(negedge clk);
    count_i = CW'(n); mode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done_o && k < 3000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic compare_out(input int n, input logic [1:0] m, input string req);
    int bad = 0;
    chk(wr_n == n, req, wr_n, n);
    for (int i = 0; i < n; i++)
      if (dst[i] !== expect_word(src[i], m)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    #3;
    chk(!busy_o && !done_o && !last_wr_o && !in_read_o && !out_write_o,
        "R1 reset", {busy_o, done_o, last_wr_o, in_read_o, out_write_o}, 0);
  endtask

  task automatic t_idle;
    load_src(8, 5);
    in_mod = 0; out_mod = 0;
    repeat (6) @(negedge clk);
    chk(rd_ptr == 0 && wr_n == 0, "R1 idle", rd_ptr + wr_n, 0);
    load_src(0, 5);
  endtask

  task automatic t_speed;
    int k;
    load_src(12, 3);
    in_mod = 0; out_mod = 0;
    pulse_start(12, 2'd0);
    wait_done(k);
    chk(k == 13, "R5 throughput", k, 13);
    compare_out(12, 2'd0, "R4 pass");
    chk(done_o && !busy_o && last_wr_o, "R7 done", {done_o, busy_o, last_wr_o}, 5);
    @(negedge clk);
    chk(!done_o, "R7 pulse", done_o, 0);
    repeat (3) @(negedge clk);
    chk(last_wr_o, "R8 hold", last_wr_o, 1);
  endtask

  task automatic t_stall(input int n, input logic [1:0] m, input int im, input int om, input string req);
    int k;
    load_src(n, n * 7);
    in_mod = im; out_mod = om;
    pulse_start(n, m);
    chk(!last_wr_o, "R8 clear", last_wr_o, 0);
    wait_done(k);
    compare_out(n, m, req);
    chk(rd_bad == 0, "R2 read gate", rd_bad, 0);
    chk(wr_bad == 0, "R3 write gate", wr_bad, 0);
    in_mod = 0; out_mod = 0;
    @(negedge clk);
  endtask

  task automatic t_zero;
    load_src(4, 9);
    pulse_start(0, 2'd0);
    chk(done_o && !busy_o, "R9 zero done", {done_o, busy_o}, 2);
    chk(!last_wr_o, "R9 no last", last_wr_o, 0);
    repeat (3) @(negedge clk);
    chk(rd_ptr == 0 && wr_n == 0, "R9 no move", rd_ptr + wr_n, 0);
  endtask

  task automatic t_restart;
    int k;
    load_src(10, 77);
    in_mod = 0; out_mod = 3;
    pulse_start(10, 2'd1);
    repeat (4) @(negedge clk);
    count_i = CW'(3); mode_i = 2'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!last_wr_o, "R8 low in run", last_wr_o, 0);
    wait_done(k);
    compare_out(10, 2'd1, "R10 ignore start");
    out_mod = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_idle();
    t_speed();
    t_stall(20, 2'd0, 3, 0, "R2 empty stall");
    t_stall(20, 2'd1, 0, 3, "R3 full stall");
    t_stall(25, 2'd2, 4, 2, "R4 mixed");
    t_stall(16, 2'd3, 5, 4, "R6 swap");
    t_stall(9, 2'd1, 0, 0, "R6 invert");
    t_stall(9, 2'd2, 0, 0, "R6 increment");
    t_zero();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule